// File: doc/BRIEF.md
# Banked Floating-Point Register File with Pair Moves

This block holds thirty-two 32-bit floating-point registers together with a 22-bit mode/control word. It executes decoded data-movement commands: loads from memory into a register, stores from a register to memory, register-to-register copies, toggles of three mode bits, and moves of the control word to and from a general register value or memory. Arithmetic and format conversion are done elsewhere. A command is presented with its operation code, a source index `m`, a destination index `n`, an extended-bank flag, a base address and an index value. The block drives a one-word memory request port and reports the new base address for the post-increment and pre-decrement forms.

Two mode bits change how indices reach the array. The bank bit swaps the two 16-register halves for every access. The pair bit widens every floating-point move to two adjacent registers. In pair mode an odd index names the pair in the opposite half. Each pair is moved high word address first. A memory error response ends the command with no architectural change.

Top module: `fpreg_bank_mover`

## Requirements
- R1: After synchronous reset all 32 registers read as zero, the control word equals the CTRL_INIT parameter (default 0), and busy and done are low.
- R2: Physical register = logical index (after the pair rule of R4), XOR 16 when `cmd_ext` is 1, XOR 16 again when control bit 21 (bank) is 1.
- R3: With control bit 20 (pair) clear, a load writes the word at the effective address into register n and a store writes register m to the effective address, one memory access each.
- R4: With pair mode set, an odd index i names the pair starting at physical i+15 (the even register in the other half), before the R2 bank swaps; an even index i names pair i, i+1.
- R5: A pair load puts the word at EA+4 into the first register of the pair and the word at EA into the second; a pair store writes the same way; the EA+4 access is issued first.
- R6: Post-increment load (op 2) uses the base as EA and returns base+8 in pair mode, base+4 otherwise; pre-decrement store (op 5) returns base-8 or base-4 and writes at that new value.
- R7: Indexed load and store (ops 0 and 3) use base + index value as EA and return the base unchanged.
- R8: Ops 7, 8 and 9 invert control bits 20, 19 and 21 respectively and change no other bit.
- R9: Op 6 copies register m to register n; in pair mode it copies the whole pair, applying the R4 rule to both indices.
- R10: Op 10 returns the control word zero-extended on rd_data; op 11 loads it from base[21:0]; op 12 subtracts 4 from the base and stores the zero-extended word there; op 13 loads it from bits 21:0 of the word at the base and returns base+4. These ops are always single-word.
- R11: An error response aborts the command: err is high with done, no register and no control bit changes, and base_out equals the original base.
- R12: done is a one-cycle pulse per command; mem_req stays high with a stable address until a response arrives; mem_req implies busy.
- R13: Opcode encoding on cmd_op: 0 indexed load, 1 load, 2 post-increment load, 3 indexed store, 4 store, 5 pre-decrement store, 6 register move, 7/8/9 toggles, 10..13 control-word moves; 14 and 15 complete with no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present; taken when busy is low |
| cmd_op | input | 4 | Operation code (R13) |
| cmd_m | input | 4 | Source register index |
| cmd_n | input | 4 | Destination register index |
| cmd_ext | input | 1 | Extended-bank access flag |
| cmd_base | input | 32 | Base address, or value for control write |
| cmd_r0 | input | 32 | Index value for indexed forms |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command completed (one cycle) |
| err | output | 1 | Completed command was aborted by a memory error |
| base_out | output | 32 | Updated base address, valid with done |
| rd_data | output | 32 | Control word read result |
| ctrl_word | output | 22 | Current control word |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word address of the request |
| mem_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response for the current request |
| mem_rsp_err | input | 1 | Response reports an error |
| mem_rdata | input | 32 | Read data |

## Verification
A wrong index mapping or a stale mode bit surfaces as wrong data in memory at the next store that names the affected register, so the bench follows every load or move with stores and finishes with a sweep over all 32 physical registers. A wrong word order shows in the first request address of a pair access in the same command. A wrong base update shows on base_out in the done cycle. A lost abort shows as changed registers or control bits on the next store or control read.

// File: rtl/fpmv_pkg.sv
package fpmv_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 32;
    localparam int NREG   = 32;
    localparam int IDX_W  = $clog2(NREG);
    localparam int LIDX_W = IDX_W - 1;
    localparam int CTRL_W = 22;
    localparam int BIT_BANK = 21;
    localparam int BIT_PAIR = 20;
    localparam int BIT_PREC = 19;

    typedef enum logic [3:0] {
        OP_LD_IDX  = 4'd0,
        OP_LD      = 4'd1,
        OP_LD_INC  = 4'd2,
        OP_ST_IDX  = 4'd3,
        OP_ST      = 4'd4,
        OP_ST_DEC  = 4'd5,
        OP_MOV     = 4'd6,
        OP_TGL_PR  = 4'd7,
        OP_TGL_PC  = 4'd8,
        OP_TGL_BK  = 4'd9,
        OP_CTL_RD  = 4'd10,
        OP_CTL_WR  = 4'd11,
        OP_CTL_ST  = 4'd12,
        OP_CTL_LD  = 4'd13,
        OP_RSV0    = 4'd14,
        OP_RSV1    = 4'd15
    } op_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_EXEC,
        SQ_MEM0,
        SQ_MEM1
    } seq_e;

    typedef struct packed {
        op_e               op;
        logic [LIDX_W-1:0] m;
        logic [LIDX_W-1:0] n;
        logic              ext;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] r0;
    } cmd_t;

    function automatic logic is_mem_op(op_e op);
        return (op <= OP_ST_DEC) || (op == OP_CTL_ST) || (op == OP_CTL_LD);
    endfunction

    function automatic logic is_store_op(op_e op);
        return (op == OP_ST_IDX) || (op == OP_ST) || (op == OP_ST_DEC) || (op == OP_CTL_ST);
    endfunction

    function automatic logic is_fload_op(op_e op);
        return (op == OP_LD_IDX) || (op == OP_LD) || (op == OP_LD_INC);
    endfunction

    function automatic logic is_ctl_op(op_e op);
        return (op == OP_CTL_RD) || (op == OP_CTL_WR) || (op == OP_CTL_ST) || (op == OP_CTL_LD);
    endfunction

    // Logical index to physical register: pair rule, then two half swaps.
    function automatic logic [IDX_W-1:0] reg_index(logic [LIDX_W-1:0] idx, logic ext,
                                                  logic pair, logic bank);
        logic [IDX_W-1:0] r;
        r = {1'b0, idx};
        if (pair && idx[0]) begin
            r = {1'b1, idx[LIDX_W-1:1], 1'b0};
        end
        r[IDX_W-1] = r[IDX_W-1] ^ ext ^ bank;
        return r;
    endfunction

endpackage

// File: rtl/fpmv_regfile.sv
module fpmv_regfile
    import fpmv_pkg::*;
#(
    parameter int N = NREG,
    parameter int W = WORD_W,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we0,
    input  logic [AW-1:0] wa0,
    input  logic [W-1:0]  wd0,
    input  logic          we1,
    input  logic [AW-1:0] wa1,
    input  logic [W-1:0]  wd1,
    input  logic [AW-1:0] ra0,
    output logic [W-1:0]  rd0,
    input  logic [AW-1:0] ra1,
    output logic [W-1:0]  rd1
);

    logic [W-1:0] cells [N];

    for (genvar g = 0; g < N; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                cells[g] <= '0;
            end else if (we0 && (wa0 == AW'(g))) begin
                cells[g] <= wd0;
            end else if (we1 && (wa1 == AW'(g))) begin
                cells[g] <= wd1;
            end
        end
    end

    assign rd0 = cells[ra0];
    assign rd1 = cells[ra1];

endmodule

// File: rtl/fpmv_agen.sv
module fpmv_agen
    import fpmv_pkg::*;
(
    input  op_e               op,
    input  logic              pair,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] r0,
    output logic [ADDR_W-1:0] addr_first,
    output logic [ADDR_W-1:0] addr_second,
    output logic [ADDR_W-1:0] base_next
);

    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(WORD_W / 8);

    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] ea;

    always_comb begin
        step      = pair ? (WORD_BYTES << 1) : WORD_BYTES;
        ea        = base;
        base_next = base;
        unique case (op)
            OP_LD_IDX, OP_ST_IDX: begin
                ea = base + r0;
            end
            OP_LD_INC, OP_CTL_LD: begin
                base_next = base + step;
            end
            OP_ST_DEC, OP_CTL_ST: begin
                base_next = base - step;
                ea        = base - step;
            end
            default: begin
                ea = base;
            end
        endcase
        // The high word of a pair is always accessed first.
        addr_first  = pair ? (ea + WORD_BYTES) : ea;
        addr_second = ea;
    end

endmodule

// File: rtl/fpmv_seq.sv
module fpmv_seq
    import fpmv_pkg::*;
#(
    parameter logic [CTRL_W-1:0] CTRL_INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  cmd_t              cmd_in,
    output cmd_t              cmd_q,
    output logic              pair,
    output logic [IDX_W-1:0]  src_idx,
    input  logic [WORD_W-1:0] rd0,
    input  logic [WORD_W-1:0] rd1,
    output logic              we0,
    output logic [IDX_W-1:0]  wa0,
    output logic [WORD_W-1:0] wd0,
    output logic              we1,
    output logic [IDX_W-1:0]  wa1,
    output logic [WORD_W-1:0] wd1,
    input  logic [ADDR_W-1:0] addr_first,
    input  logic [ADDR_W-1:0] addr_second,
    input  logic [ADDR_W-1:0] base_next,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [ADDR_W-1:0] base_out,
    output logic [WORD_W-1:0] rd_data,
    output logic [CTRL_W-1:0] ctrl_word
);

    seq_e              state_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [WORD_W-1:0] hold_q;
    logic              done_q;
    logic              err_q;
    logic [ADDR_W-1:0] base_q;
    logic [WORD_W-1:0] rd_q;
    logic [IDX_W-1:0]  dst_idx;
    logic [WORD_W-1:0] ctrl_ext;
    logic              rsp_ok;

    assign ctrl_ext = {{(WORD_W - CTRL_W){1'b0}}, ctrl_q};
    assign pair     = ctrl_q[BIT_PAIR] && !is_ctl_op(cmd_q.op);
    assign src_idx  = reg_index(cmd_q.m, cmd_q.ext, pair, ctrl_q[BIT_BANK]);
    assign dst_idx  = reg_index(cmd_q.n, cmd_q.ext, pair, ctrl_q[BIT_BANK]);
    assign rsp_ok   = mem_rsp_valid && !mem_rsp_err;

    // Memory request side
    always_comb begin
        mem_req   = (state_q == SQ_MEM0) || (state_q == SQ_MEM1);
        mem_we    = mem_req && is_store_op(cmd_q.op);
        mem_addr  = (state_q == SQ_MEM1) ? addr_second : addr_first;
        if (cmd_q.op == OP_CTL_ST) begin
            mem_wdata = ctrl_ext;
        end else if (state_q == SQ_MEM1) begin
            mem_wdata = rd1;
        end else begin
            mem_wdata = rd0;
        end
    end

    // Register file write ports: commits happen only on the final step.
    always_comb begin
        we0 = 1'b0;
        we1 = 1'b0;
        wa0 = dst_idx;
        wa1 = dst_idx | IDX_W'(1);
        wd0 = mem_rdata;
        wd1 = mem_rdata;
        unique case (state_q)
            SQ_MEM0: begin
                we0 = rsp_ok && is_fload_op(cmd_q.op) && !pair;
            end
            SQ_MEM1: begin
                we0 = rsp_ok && is_fload_op(cmd_q.op);
                we1 = rsp_ok && is_fload_op(cmd_q.op);
                wd0 = hold_q;
            end
            SQ_EXEC: begin
                we0 = (cmd_q.op == OP_MOV);
                we1 = (cmd_q.op == OP_MOV) && pair;
                wd0 = rd0;
                wd1 = rd1;
            end
            default: begin
                we0 = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            cmd_q   <= '0;
            ctrl_q  <= CTRL_INIT;
            hold_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            base_q  <= '0;
            rd_q    <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state_q)
                SQ_IDLE: begin
                    if (cmd_valid) begin
                        cmd_q   <= cmd_in;
                        state_q <= is_mem_op(cmd_in.op) ? SQ_MEM0 : SQ_EXEC;
                    end
                end
                SQ_EXEC: begin
                    done_q  <= 1'b1;
                    base_q  <= cmd_q.base;
                    state_q <= SQ_IDLE;
                    case (cmd_q.op)
                        OP_TGL_PR: ctrl_q[BIT_PAIR] <= ~ctrl_q[BIT_PAIR];
                        OP_TGL_PC: ctrl_q[BIT_PREC] <= ~ctrl_q[BIT_PREC];
                        OP_TGL_BK: ctrl_q[BIT_BANK] <= ~ctrl_q[BIT_BANK];
                        OP_CTL_RD: rd_q <= ctrl_ext;
                        OP_CTL_WR: ctrl_q <= cmd_q.base[CTRL_W-1:0];
                        default:   ctrl_q <= ctrl_q;
                    endcase
                end
                SQ_MEM0: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err) begin
                            done_q  <= 1'b1;
                            err_q   <= 1'b1;
                            base_q  <= cmd_q.base;
                            state_q <= SQ_IDLE;
                        end else if (pair) begin
                            hold_q  <= mem_rdata;
                            state_q <= SQ_MEM1;
                        end else begin
                            done_q  <= 1'b1;
                            base_q  <= base_next;
                            state_q <= SQ_IDLE;
                            if (cmd_q.op == OP_CTL_LD) begin
                                ctrl_q <= mem_rdata[CTRL_W-1:0];
                            end
                        end
                    end
                end
                SQ_MEM1: begin
                    if (mem_rsp_valid) begin
                        done_q  <= 1'b1;
                        err_q   <= mem_rsp_err;
                        base_q  <= mem_rsp_err ? cmd_q.base : base_next;
                        state_q <= SQ_IDLE;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != SQ_IDLE);
    assign done      = done_q;
    assign err       = err_q;
    assign base_out  = base_q;
    assign rd_data   = rd_q;
    assign ctrl_word = ctrl_q;

endmodule

// File: rtl/fpreg_bank_mover.sv
module fpreg_bank_mover
    import fpmv_pkg::*;
#(
    parameter logic [CTRL_W-1:0] CTRL_INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [3:0]        cmd_m,
    input  logic [3:0]        cmd_n,
    input  logic              cmd_ext,
    input  logic [31:0]       cmd_base,
    input  logic [31:0]       cmd_r0,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [31:0]       base_out,
    output logic [31:0]       rd_data,
    output logic [21:0]       ctrl_word,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    input  logic [31:0]       mem_rdata
);

    cmd_t              cmd_in;
    cmd_t              cmd_q;
    logic              pair;
    logic [IDX_W-1:0]  src_idx;
    logic [WORD_W-1:0] rd0, rd1;
    logic              we0, we1;
    logic [IDX_W-1:0]  wa0, wa1;
    logic [WORD_W-1:0] wd0, wd1;
    logic [ADDR_W-1:0] addr_first, addr_second, base_next;

    always_comb begin
        cmd_in.op   = op_e'(cmd_op);
        cmd_in.m    = cmd_m;
        cmd_in.n    = cmd_n;
        cmd_in.ext  = cmd_ext;
        cmd_in.base = cmd_base;
        cmd_in.r0   = cmd_r0;
    end

    fpmv_seq #(.CTRL_INIT(CTRL_INIT)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid    (cmd_valid),
        .cmd_in       (cmd_in),
        .cmd_q        (cmd_q),
        .pair         (pair),
        .src_idx      (src_idx),
        .rd0          (rd0),
        .rd1          (rd1),
        .we0          (we0),
        .wa0          (wa0),
        .wd0          (wd0),
        .we1          (we1),
        .wa1          (wa1),
        .wd1          (wd1),
        .addr_first   (addr_first),
        .addr_second  (addr_second),
        .base_next    (base_next),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_err  (mem_rsp_err),
        .mem_rdata    (mem_rdata),
        .busy         (busy),
        .done         (done),
        .err          (err),
        .base_out     (base_out),
        .rd_data      (rd_data),
        .ctrl_word    (ctrl_word)
    );

    fpmv_agen u_agen (
        .op         (cmd_q.op),
        .pair       (pair),
        .base       (cmd_q.base),
        .r0         (cmd_q.r0),
        .addr_first (addr_first),
        .addr_second(addr_second),
        .base_next  (base_next)
    );

    fpmv_regfile #(.N(NREG), .W(WORD_W)) u_rf (
        .clk(clk),
        .rst(rst),
        .we0(we0),
        .wa0(wa0),
        .wd0(wd0),
        .we1(we1),
        .wa1(wa1),
        .wd1(wd1),
        .ra0(src_idx),
        .rd0(rd0),
        .ra1(src_idx | IDX_W'(1)),
        .rd1(rd1)
    );

endmodule

// File: rtl/fpmv_chk.sv
module fpmv_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic        mem_req,
    input logic        mem_rsp_valid,
    input logic [31:0] mem_addr,
    input logic [21:0] ctrl_word
);

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_addr)));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R12
    req_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    // R11
    err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    // R10
    ctrl_commit_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_word) |-> done);

    // R12
    idle_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

bind fpreg_bank_mover fpmv_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .busy         (busy),
    .done         (done),
    .err          (err),
    .mem_req      (mem_req),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_addr     (mem_addr),
    .ctrl_word    (ctrl_word)
);

// File: tb/fpreg_bank_mover_tb.sv
module fpreg_bank_mover_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [3:0]  cmd_m = '0;
    logic [3:0]  cmd_n = '0;
    logic        cmd_ext = 1'b0;
    logic [31:0] cmd_base = '0;
    logic [31:0] cmd_r0 = '0;
    logic        busy, done, err;
    logic [31:0] base_out, rd_data;
    logic [21:0] ctrl_word;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic        mem_rsp_err = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    fpreg_bank_mover u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_m(cmd_m), .cmd_n(cmd_n), .cmd_ext(cmd_ext), .cmd_base(cmd_base),
        .cmd_r0(cmd_r0), .busy(busy), .done(done), .err(err),
        .base_out(base_out), .rd_data(rd_data), .ctrl_word(ctrl_word),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_err(mem_rsp_err), .mem_rdata(mem_rdata)
    );

    // Bench memory and reference state
    logic [31:0] mem [256];
    logic [31:0] ref_rf [32];
    logic [21:0] ref_ctrl;
    logic [31:0] err_addr = 32'hFFFF_FFF0;
    logic [31:0] acc_addr [2];
    int          acc_cnt;
    int          n_checks = 0;
    int          n_fail = 0;

    // Memory responder: answers one cycle after a request is seen.
    always @(negedge clk) begin
        if (mem_req && !mem_rsp_valid) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_err   = (mem_addr == err_addr);
            if (acc_cnt < 2) acc_addr[acc_cnt] = mem_addr;
            acc_cnt = acc_cnt + 1;
            if (!mem_rsp_err) begin
                if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
                else        mem_rdata = mem[mem_addr[9:2]];
            end
        end else begin
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int bphys(input int idx, input bit ext, input bit pair, input bit bank);
        int r;
        r = (pair && (idx % 2 == 1)) ? idx + 15 : idx;
        if (ext)  r = r ^ 16;
        if (bank) r = r ^ 16;
        return r;
    endfunction

    function automatic logic [31:0] rdmem(input logic [31:0] a);
        return mem[a[9:2]];
    endfunction

    task automatic issue(input int op, input int m, input int n, input bit ext,
                         input logic [31:0] base, input logic [31:0] r0);
        int guard;
        @(negedge clk);
        acc_cnt   = 0;
        cmd_valid = 1'b1;
        cmd_op    = 4'(op);
        cmd_m     = 4'(m);
        cmd_n     = 4'(n);
        cmd_ext   = ext;
        cmd_base  = base;
        cmd_r0    = r0;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R12 busy during command", 32'(busy), 32'd1);
        guard = 0;
        while (!done && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        chk("R12 done seen", 32'(done), 32'd1);
    endtask

    // Issue one command, predict and check its results against the reference.
    task automatic do_op(input int op, input int m, input int n, input bit ext,
                         input logic [31:0] base, input logic [31:0] r0);
        bit pair, bank, memop, eexp;
        logic [31:0] ea, nb, a1, a2, step;
        int dp, sp;
        logic [31:0] t0, t1;
        bank  = ref_ctrl[21];
        pair  = ref_ctrl[20] && (op <= 6);
        step  = pair ? 32'd8 : 32'd4;
        ea = base; nb = base;
        case (op)
            0, 3:  ea = base + r0;
            2:     nb = base + step;
            13:    nb = base + 4;
            5:     begin nb = base - step; ea = nb; end
            12:    begin nb = base - 4; ea = nb; end
            default: ;
        endcase
        memop = (op <= 5) || (op == 12) || (op == 13);
        a1 = pair ? ea + 4 : ea;
        a2 = ea;
        eexp = memop && ((err_addr == a1) || (pair && err_addr == a2));
        dp = bphys(n, ext, pair, bank);
        sp = bphys(m, ext, pair, bank);
        issue(op, m, n, ext, base, r0);
        chk("R11 err flag", 32'(err), 32'(eexp));
        chk(op == 2 || op == 5 ? "R6 base update" : (op == 0 || op == 3 ? "R7 base kept" : "R10 base"),
            base_out, eexp ? base : nb);
        if (memop && !eexp) begin
            chk(pair ? "R5 high word first" : "R3 access address", acc_addr[0], a1);
            chk("R12 access count", 32'(acc_cnt), pair ? 32'd2 : 32'd1);
        end
        if (eexp) begin
            chk("R11 control kept", 32'(ctrl_word), 32'(ref_ctrl));
        end else begin
            case (op)
                0, 1, 2: begin
                    if (pair) begin
                        ref_rf[dp]     = rdmem(a1);
                        ref_rf[dp + 1] = rdmem(a2);
                    end else begin
                        ref_rf[dp] = rdmem(ea);
                    end
                end
                3, 4, 5: begin
                    chk(pair ? "R5 pair store high" : "R3 store word", rdmem(a1), ref_rf[sp]);
                    if (pair) chk("R5 pair store low", rdmem(a2), ref_rf[sp + 1]);
                end
                6: begin
                    t0 = ref_rf[sp];
                    t1 = ref_rf[sp + 1];
                    ref_rf[dp] = t0;
                    if (pair) ref_rf[dp + 1] = t1;
                end
                7: begin ref_ctrl[20] = ~ref_ctrl[20]; chk("R8 toggle bit 20", 32'(ctrl_word), 32'(ref_ctrl)); end
                8: begin ref_ctrl[19] = ~ref_ctrl[19]; chk("R8 toggle bit 19", 32'(ctrl_word), 32'(ref_ctrl)); end
                9: begin ref_ctrl[21] = ~ref_ctrl[21]; chk("R8 toggle bit 21", 32'(ctrl_word), 32'(ref_ctrl)); end
                10: chk("R10 control read", rd_data, 32'(ref_ctrl));
                11: begin ref_ctrl = base[21:0]; chk("R10 control write masked", 32'(ctrl_word), 32'(ref_ctrl)); end
                12: chk("R10 control store", rdmem(ea), 32'(ref_ctrl));
                13: begin ref_ctrl = rdmem(ea)[21:0]; chk("R10 control load", 32'(ctrl_word), 32'(ref_ctrl)); end
                default: chk("R13 reserved op no effect", 32'(ctrl_word), 32'(ref_ctrl));
            endcase
        end
        @(negedge clk);
        chk("R12 done single pulse", 32'(done), 32'd0);
    endtask

    // Read every physical register out through single stores.
    task automatic sweep(input string tag);
        do_op(11, 0, 0, 0, 32'h0, 32'h0);
        for (int k = 0; k < 32; k++) begin
            issue(4, k % 16, 0, k >= 16, 32'h3C0, 32'h0);
            chk(tag, rdmem(32'h3C0), ref_rf[k]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        int s;
        s = $urandom(32'd2024);
        for (int i = 0; i < 256; i++) mem[i] = $urandom;
        for (int i = 0; i < 32; i++) ref_rf[i] = '0;
        ref_ctrl = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 control init", 32'(ctrl_word), 32'h0);
        chk("R1 busy low", 32'(busy), 32'd0);
        chk("R1 done low", 32'(done), 32'd0);
        sweep("R1 register zero");

        // R3 / R7 single loads and stores
        mem[32'h100 >> 2] = 32'hA5A5_0001;
        do_op(1, 0, 3, 0, 32'h100, 0);
        do_op(4, 3, 0, 0, 32'h200, 0);
        do_op(0, 0, 7, 0, 32'h100, 32'h20);
        do_op(3, 7, 0, 0, 32'h210, 32'h8);
        // R6 single post-increment / pre-decrement
        do_op(2, 0, 9, 0, 32'h140, 0);
        do_op(5, 9, 0, 0, 32'h240, 0);

        // R8 pair mode on; R5 pair order; R4 odd index
        do_op(7, 0, 0, 0, 0, 0);
        mem[32'h184 >> 2] = 32'h1111_0004;
        mem[32'h180 >> 2] = 32'h2222_0000;
        do_op(1, 0, 2, 0, 32'h180, 0);
        do_op(1, 0, 5, 0, 32'h180, 0);
        do_op(2, 0, 10, 0, 32'h190, 0);
        do_op(5, 5, 0, 0, 32'h260, 0);
        do_op(3, 11, 0, 0, 32'h270, 32'h10);
        // R9 pair and single moves
        do_op(6, 5, 12, 0, 0, 0);
        do_op(6, 2, 13, 1, 0, 0);
        do_op(7, 0, 0, 0, 0, 0);
        do_op(6, 3, 14, 0, 0, 0);
        // R2 bank swap
        do_op(9, 0, 0, 0, 0, 0);
        do_op(4, 4, 0, 0, 32'h2A0, 0);
        do_op(4, 4, 0, 1, 32'h2A4, 0);
        do_op(9, 0, 0, 0, 0, 0);
        sweep("R2 R4 R9 physical contents");

        // R8 precision toggle and R10 control moves
        do_op(8, 0, 0, 0, 0, 0);
        do_op(8, 0, 0, 0, 0, 0);
        do_op(11, 0, 0, 0, 32'hFFFF_FFFF, 0);
        do_op(10, 0, 0, 0, 0, 0);
        do_op(12, 0, 0, 0, 32'h300, 0);
        mem[32'h310 >> 2] = 32'hFFC0_0003;
        do_op(13, 0, 0, 0, 32'h310, 0);
        do_op(10, 0, 0, 0, 0, 0);
        // R13 reserved codes
        do_op(14, 0, 0, 0, 32'h44, 0);
        do_op(15, 0, 0, 0, 32'h48, 0);

        // R11 error aborts
        do_op(11, 0, 0, 0, 32'h0010_0000, 0);
        err_addr = 32'h140;
        do_op(2, 0, 6, 0, 32'h140, 0);
        err_addr = 32'h14C;
        do_op(2, 0, 8, 0, 32'h148, 0);
        err_addr = 32'h1F8;
        do_op(5, 4, 0, 0, 32'h200, 0);
        do_op(11, 0, 0, 0, 32'h0, 0);
        err_addr = 32'h150;
        do_op(13, 0, 0, 0, 32'h150, 0);
        do_op(1, 0, 1, 0, 32'h150, 0);
        err_addr = 32'hFFFF_FFF0;
        sweep("R11 registers unchanged");

        // Constrained random mix
        for (int i = 0; i < 300; i++) begin
            int op;
            int pick;
            pick = $urandom_range(0, 9);
            case (pick)
                0: op = 0; 1: op = 1; 2: op = 2; 3: op = 3; 4: op = 4;
                5: op = 5; 6: op = 6; 7: op = 7; 8: op = 9; default: op = 8;
            endcase
            do_op(op, $urandom_range(0, 15), $urandom_range(0, 15), 1'($urandom_range(0, 1)),
                  32'h100 + 32'($urandom_range(0, 96)) * 4, 32'($urandom_range(0, 16)) * 4);
        end
        sweep("R2 R3 R5 R9 random final contents");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule